// File: doc/BRIEF.md
# Eight-Bit Arithmetic/Logic Unit with Status Flags

This block is the execution datapath of a small eight-bit processor core. It takes two data operands, an operation code and a flag selector, and returns a result combinationally. Alongside the datapath it keeps an eight-bit status register. For each operation the block rewrites only the flags that belong to that operation. Every other status bit keeps its value.

The carry input of every carrying operation comes from the status register's own C bit. A chain of add-with-carry or subtract-with-carry operations therefore handles numbers wider than eight bits. For subtract-with-carry the zero flag is sticky, so a multi-byte compare leaves Z set only when every byte was zero. The status register loads only in a cycle where `exec_en` is high. In other cycles the result can still be observed and the flags are held.

Top module: `alu8_core`

## Requirements
- R1: After reset the status register reads 0x00. The status bits are, from bit 7 down to bit 0: I, T, H, S, V, N, Z, C. While `exec_en` is low the status register keeps its value.
- R2: ADD (op 0) returns A+B. ADC (op 1) returns A+B+C. Both write C (carry out of bit 7), H (carry out of bit 3), V (signed overflow), N (result bit 7) and Z (result is zero).
- R3: SUB (op 2) returns A-B. It writes C as the borrow out of bit 7, H as the borrow from bit 3, V as signed overflow, and N and Z from the result.
- R4: SBC (op 3) returns A-B-C and writes C, H, V and N like SUB. Its Z is set only when the result is zero and Z was already set.
- R5: AND (op 4), OR (op 5), XOR (op 6) and mask-clear (op 7, A AND NOT B) write N and Z and clear V. C and H are left unchanged.
- R6: COM (op 8) returns 0xFF-A, sets C and clears V. NEG (op 9) returns 0x00-A. It sets C when the result is non-zero, sets V only for a result of 0x80, and sets H when bit 3 of A or bit 3 of the result is one.
- R7: INC (op 10) and DEC (op 11) return A+1 and A-1 and write only N, Z, V and S. V is set for the step 0x7F to 0x80 on INC and for the step 0x80 to 0x7F on DEC.
- R8: LSL (op 12) shifts left and fills bit 0 with zero. LSR (op 13) shifts right and fills bit 7 with zero. The bit shifted out goes to C.
- R9: ROL (op 14) and ROR (op 15) rotate through C. ASR (op 16) keeps bit 7 and moves bit 0 into C. After any of ops 12 to 16, V equals N XOR C, and H is unchanged.
- R10: SWAP (op 17) exchanges the two nibbles of A and leaves every status bit unchanged.
- R11: FSET (op 18) sets and FCLR (op 19) clears the one status bit numbered by `flag_sel`. The other seven bits are unchanged and the result is A.
- R12: After ops 0 to 16, S equals N XOR V.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exec_en | input | 1 | Commit the flag update of the current operation |
| op_sel | input | 5 | Operation code (0 to 19) |
| opnd_a | input | 8 | First operand, destination value |
| opnd_b | input | 8 | Second operand, register value or constant |
| flag_sel | input | 3 | Status bit index for FSET/FCLR |
| alu_out | output | 8 | Combinational result |
| sreg_out | output | 8 | Registered status flags |

## Verification
The assertions assume that `op_sel`, `flag_sel` and `exec_en` carry known values at every clock edge after reset. They also assume that only the codes 0 to 19 are used when a flag change matters, because undefined codes are treated as a pass-through that touches no flag. The stimulus draws operation codes only from the defined range and drives every input at the falling edge. It mixes random operands with directed corner values such as 0x7F, 0x80, 0x00 and 0xFF, and it sometimes drops `exec_en` so that hold cycles fall between operations that depend on carry.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int OP_W   = 5;
    localparam int SREG_W = 8;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBC  = 5'd3,
        OP_AND  = 5'd4,
        OP_OR   = 5'd5,
        OP_XOR  = 5'd6,
        OP_CBR  = 5'd7,
        OP_COM  = 5'd8,
        OP_NEG  = 5'd9,
        OP_INC  = 5'd10,
        OP_DEC  = 5'd11,
        OP_LSL  = 5'd12,
        OP_LSR  = 5'd13,
        OP_ROL  = 5'd14,
        OP_ROR  = 5'd15,
        OP_ASR  = 5'd16,
        OP_SWAP = 5'd17,
        OP_FSET = 5'd18,
        OP_FCLR = 5'd19
    } alu_op_e;

    // packed from bit 7 (i) down to bit 0 (c)
    typedef struct packed {
        logic i;
        logic t;
        logic h;
        logic s;
        logic v;
        logic n;
        logic z;
        logic c;
    } sreg_t;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
    import alu8_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int HALF_BIT = 3
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output logic              c_o,
    output logic              h_o,
    output logic              v_o
);

    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] x_op;
    logic [DATA_W-1:0] y_op;
    logic              ci;
    logic              do_sub;
    logic [DATA_W:0]   wide;

    // operand steering: NEG is 0 - A, INC/DEC use a constant one
    always_comb begin
        x_op   = a;
        y_op   = b;
        ci     = 1'b0;
        do_sub = 1'b0;
        case (op)
            OP_ADC: ci = cin;
            OP_SUB: do_sub = 1'b1;
            OP_SBC: begin
                do_sub = 1'b1;
                ci     = cin;
            end
            OP_NEG: begin
                x_op   = '0;
                y_op   = a;
                do_sub = 1'b1;
            end
            OP_INC: y_op = DATA_W'(1);
            OP_DEC: begin
                y_op   = DATA_W'(1);
                do_sub = 1'b1;
            end
            default: ;
        endcase
    end

    always_comb begin
        if (do_sub) begin
            wide = {1'b0, x_op} - {1'b0, y_op} - (DATA_W+1)'(ci);
        end else begin
            wide = {1'b0, x_op} + {1'b0, y_op} + (DATA_W+1)'(ci);
        end
        res = wide[MSB:0];
        c_o = wide[DATA_W];
    end

    // half carry / half borrow and signed overflow from operand and result sign bits
    always_comb begin
        if (do_sub) begin
            h_o = (~x_op[HALF_BIT] & y_op[HALF_BIT]) |
                  (y_op[HALF_BIT] & res[HALF_BIT]) |
                  (res[HALF_BIT] & ~x_op[HALF_BIT]);
            v_o = (x_op[MSB] & ~y_op[MSB] & ~res[MSB]) |
                  (~x_op[MSB] & y_op[MSB] & res[MSB]);
        end else begin
            h_o = (x_op[HALF_BIT] & y_op[HALF_BIT]) |
                  (y_op[HALF_BIT] & ~res[HALF_BIT]) |
                  (~res[HALF_BIT] & x_op[HALF_BIT]);
            v_o = (x_op[MSB] & y_op[MSB] & ~res[MSB]) |
                  (~x_op[MSB] & ~y_op[MSB] & res[MSB]);
        end
    end

endmodule

// File: rtl/alu8_bitwise.sv
module alu8_bitwise
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] res
);

    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] swapped;

    generate
        if (DATA_W % 2 == 0) begin : g_even
            assign swapped = {a[HALF_W-1:0], a[DATA_W-1:HALF_W]};
        end else begin : g_odd
            assign swapped = a;
        end
    endgenerate

    always_comb begin
        case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_CBR:  res = a & ~b;
            OP_COM:  res = ~a;
            OP_SWAP: res = swapped;
            default: res = a;
        endcase
    end

endmodule

// File: rtl/alu8_shifter.sv
module alu8_shifter
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output logic              c_o
);

    localparam int MSB = DATA_W - 1;

    always_comb begin
        res = a;
        c_o = cin;
        case (op)
            OP_LSL: begin
                res = {a[MSB-1:0], 1'b0};
                c_o = a[MSB];
            end
            OP_LSR: begin
                res = {1'b0, a[MSB:1]};
                c_o = a[0];
            end
            OP_ROL: begin
                res = {a[MSB-1:0], cin};
                c_o = a[MSB];
            end
            OP_ROR: begin
                res = {cin, a[MSB:1]};
                c_o = a[0];
            end
            OP_ASR: begin
                res = {a[MSB], a[MSB:1]};
                c_o = a[0];
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int HALF_BIT = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    exec_en,
    input  logic [OP_W-1:0]         op_sel,
    input  logic [DATA_W-1:0]       opnd_a,
    input  logic [DATA_W-1:0]       opnd_b,
    input  logic [$clog2(SREG_W)-1:0] flag_sel,
    output logic [DATA_W-1:0]       alu_out,
    output logic [SREG_W-1:0]       sreg_out
);

    localparam int MSB = DATA_W - 1;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        sreg_t             sreg;
    } step_t;

    alu_op_e           op;
    sreg_t             sreg_q;
    step_t             nxt_d;

    logic [DATA_W-1:0] as_res;
    logic              as_c;
    logic              as_h;
    logic              as_v;
    logic [DATA_W-1:0] bw_res;
    logic [DATA_W-1:0] sh_res;
    logic              sh_c;

    assign op = alu_op_e'(op_sel);

    alu8_addsub #(
        .DATA_W   (DATA_W),
        .HALF_BIT (HALF_BIT)
    ) u_addsub (
        .op  (op),
        .a   (opnd_a),
        .b   (opnd_b),
        .cin (sreg_q.c),
        .res (as_res),
        .c_o (as_c),
        .h_o (as_h),
        .v_o (as_v)
    );

    alu8_bitwise #(
        .DATA_W (DATA_W)
    ) u_bitwise (
        .op  (op),
        .a   (opnd_a),
        .b   (opnd_b),
        .res (bw_res)
    );

    alu8_shifter #(
        .DATA_W (DATA_W)
    ) u_shifter (
        .op  (op),
        .a   (opnd_a),
        .cin (sreg_q.c),
        .res (sh_res),
        .c_o (sh_c)
    );

    always_comb begin
        sreg_t             fl;
        logic [SREG_W-1:0] fbits;
        logic              touch_nz;
        logic              shift_v;

        fl       = sreg_q;
        fbits    = sreg_q;
        touch_nz = 1'b0;
        shift_v  = 1'b0;
        nxt_d.res = opnd_a;

        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG: begin
                nxt_d.res = as_res;
                fl.h      = as_h;
                fl.v      = as_v;
                fl.c      = as_c;
                touch_nz  = 1'b1;
            end
            OP_INC, OP_DEC: begin
                nxt_d.res = as_res;
                fl.v      = as_v;
                touch_nz  = 1'b1;
            end
            OP_AND, OP_OR, OP_XOR, OP_CBR: begin
                nxt_d.res = bw_res;
                fl.v      = 1'b0;
                touch_nz  = 1'b1;
            end
            OP_COM: begin
                nxt_d.res = bw_res;
                fl.v      = 1'b0;
                fl.c      = 1'b1;
                touch_nz  = 1'b1;
            end
            OP_SWAP: begin
                nxt_d.res = bw_res;
            end
            OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR: begin
                nxt_d.res = sh_res;
                fl.c      = sh_c;
                touch_nz  = 1'b1;
                shift_v   = 1'b1;
            end
            OP_FSET: begin
                fbits[flag_sel] = 1'b1;
                fl              = sreg_t'(fbits);
            end
            OP_FCLR: begin
                fbits[flag_sel] = 1'b0;
                fl              = sreg_t'(fbits);
            end
            default: ;
        endcase

        if (touch_nz) begin
            fl.n = nxt_d.res[MSB];
            if (op == OP_SBC) begin
                fl.z = (nxt_d.res == '0) & sreg_q.z;
            end else begin
                fl.z = (nxt_d.res == '0);
            end
            if (shift_v) begin
                fl.v = fl.n ^ fl.c;
            end
            fl.s = fl.n ^ fl.v;
        end

        nxt_d.sreg = exec_en ? fl : sreg_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg_q <= '0;
        end else begin
            sreg_q <= nxt_d.sreg;
        end
    end

    assign alu_out  = nxt_d.res;
    assign sreg_out = sreg_q;

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
    import alu8_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              exec_en,
    input logic [OP_W-1:0]   op_sel,
    input logic [2:0]        flag_sel,
    input logic [SREG_W-1:0] sreg_out
);

    alu_op_e op;
    assign op = alu_op_e'(op_sel);

    logic is_logic;
    logic is_shift;
    logic is_incdec;
    logic sets_s;

    assign is_logic  = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) || (op == OP_CBR);
    assign is_shift  = (op == OP_LSL) || (op == OP_LSR) || (op == OP_ROL) ||
                       (op == OP_ROR) || (op == OP_ASR);
    assign is_incdec = (op == OP_INC) || (op == OP_DEC);
    assign sets_s    = (op_sel <= 5'd16);

    assert_hold_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_en |=> $stable(sreg_out));

    assert_sbc_zero_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && op == OP_SBC && !sreg_out[1]) |=> !sreg_out[1]);

    assert_logic_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && is_logic) |=>
            (!sreg_out[3] && sreg_out[0] == $past(sreg_out[0]) && sreg_out[5] == $past(sreg_out[5])));

    assert_com_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && op == OP_COM) |=> (sreg_out[0] && !sreg_out[3]));

    assert_incdec_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && is_incdec) |=>
            (sreg_out[0] == $past(sreg_out[0]) && sreg_out[5] == $past(sreg_out[5])));

    assert_shift_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && is_shift) |=>
            (sreg_out[3] == (sreg_out[2] ^ sreg_out[0]) && sreg_out[5] == $past(sreg_out[5])));

    assert_swap_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && op == OP_SWAP) |=> $stable(sreg_out));

    assert_flag_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && op == OP_FSET) |=> sreg_out[$past(flag_sel)]);

    assert_flag_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && op == OP_FCLR) |=> !sreg_out[$past(flag_sel)]);

    assert_sign_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && sets_s) |=> (sreg_out[4] == (sreg_out[3] ^ sreg_out[2])));

endmodule

bind alu8_core alu8_core_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .exec_en  (exec_en),
    .op_sel   (op_sel),
    .flag_sel (flag_sel),
    .sreg_out (sreg_out)
);

// File: tb/test_alu8_core.sv
module test_alu8_core;

    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 4000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       exec_en;
    logic [4:0] op_sel;
    logic [7:0] opnd_a;
    logic [7:0] opnd_b;
    logic [2:0] flag_sel;
    logic [7:0] alu_out;
    logic [7:0] sreg_out;

    int total = 0;
    int bad   = 0;
    int msr   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu8_core i_alu8_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .exec_en  (exec_en),
        .op_sel   (op_sel),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .flag_sel (flag_sel),
        .alu_out  (alu_out),
        .sreg_out (sreg_out)
    );

    function automatic int sx(int x);
        return (x >= 128) ? x - 256 : x;
    endfunction

    function automatic int put(int f, int k, int v);
        return (f & ~(1 << k)) | ((v & 1) << k);
    endfunction

    // returns result in bits 7:0 and next status in bits 15:8
    function automatic int model(int op, int a, int b, int fs, int sr);
        int c  = sr & 1;
        int zo = (sr >> 1) & 1;
        int r  = a;
        int f  = sr;
        int t, ci, n, v;
        bit nz = 1'b0;
        case (op)
            0, 1: begin
                ci = (op == 1) ? c : 0;
                t  = a + b + ci;
                r  = t & 255;
                f  = put(f, 0, int'(t > 255));
                f  = put(f, 5, int'(((a & 15) + (b & 15) + ci) > 15));
                t  = sx(a) + sx(b) + ci;
                f  = put(f, 3, int'(t > 127 || t < -128));
                nz = 1'b1;
            end
            2, 3: begin
                ci = (op == 3) ? c : 0;
                t  = a - b - ci;
                r  = t & 255;
                f  = put(f, 0, int'(t < 0));
                f  = put(f, 5, int'(((a & 15) - (b & 15) - ci) < 0));
                t  = sx(a) - sx(b) - ci;
                f  = put(f, 3, int'(t > 127 || t < -128));
                nz = 1'b1;
            end
            4: begin r = a & b;         f = put(f, 3, 0); nz = 1'b1; end
            5: begin r = a | b;         f = put(f, 3, 0); nz = 1'b1; end
            6: begin r = a ^ b;         f = put(f, 3, 0); nz = 1'b1; end
            7: begin r = a & (255 - b); f = put(f, 3, 0); nz = 1'b1; end
            8: begin
                r  = 255 - a;
                f  = put(f, 3, 0);
                f  = put(f, 0, 1);
                nz = 1'b1;
            end
            9: begin
                r  = (256 - a) & 255;
                f  = put(f, 0, int'(a != 0));
                f  = put(f, 5, int'((a & 15) != 0));
                f  = put(f, 3, int'(a == 128));
                nz = 1'b1;
            end
            10: begin r = (a + 1) & 255;   f = put(f, 3, int'(a == 127)); nz = 1'b1; end
            11: begin r = (a + 255) & 255; f = put(f, 3, int'(a == 128)); nz = 1'b1; end
            12: begin r = (a * 2) & 255;       f = put(f, 0, a / 128); nz = 1'b1; end
            13: begin r = a / 2;               f = put(f, 0, a % 2);   nz = 1'b1; end
            14: begin r = (a * 2 + c) & 255;   f = put(f, 0, a / 128); nz = 1'b1; end
            15: begin r = a / 2 + c * 128;     f = put(f, 0, a % 2);   nz = 1'b1; end
            16: begin r = a / 2 + (a & 128);   f = put(f, 0, a % 2);   nz = 1'b1; end
            17: r = ((a & 15) * 16) + (a / 16);
            18: f = f | (1 << fs);
            19: f = f & ~(1 << fs);
            default: ;
        endcase
        if (nz) begin
            n = int'(r >= 128);
            f = put(f, 2, n);
            if (op == 3) f = put(f, 1, int'(r == 0 && zo == 1));
            else         f = put(f, 1, int'(r == 0));
            if (op >= 12 && op <= 16) f = put(f, 3, n ^ (f & 1));
            v = (f >> 3) & 1;
            f = put(f, 4, n ^ v);
        end
        return (r & 255) | ((f & 255) << 8);
    endfunction

    function automatic string tag_of(int op);
        case (op)
            0, 1:       return "R2";
            2:          return "R3";
            3:          return "R4";
            4, 5, 6, 7: return "R5";
            8, 9:       return "R6";
            10, 11:     return "R7";
            12, 13:     return "R8";
            14, 15, 16: return "R9";
            17:         return "R10";
            default:    return "R11";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%02h expected=0x%02h at %0t", tag, act, exp, $time);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic run(input int op, input int a, input int b, input int fs, input bit ex);
        int e, er, es;
        exec_en  = ex;
        op_sel   = 5'(op);
        opnd_a   = 8'(a);
        opnd_b   = 8'(b);
        flag_sel = 3'(fs);
        #1;
        e  = model(op, a, b, fs, msr);
        er = e & 255;
        es = (e >> 8) & 255;
        check(int'(alu_out) == er, tag_of(op), int'(alu_out), er);
        @(negedge clk);
        if (ex) begin
            msr = es;
            check(int'(sreg_out) == msr, tag_of(op), int'(sreg_out), msr);
            if (op <= 16) begin
                // R12: S follows N xor V
                check(sreg_out[4] == (sreg_out[3] ^ sreg_out[2]), "R12",
                      int'(sreg_out), msr);
            end
        end else begin
            check(int'(sreg_out) == msr, "R1", int'(sreg_out), msr);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired actual=0x00 expected=0x00");
        bad++;
        total++;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240613));
        rst_n    = 1'b0;
        exec_en  = 1'b0;
        op_sel   = '0;
        opnd_a   = '0;
        opnd_b   = '0;
        flag_sel = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset value
        check(sreg_out == 8'h00, "R1", int'(sreg_out), 0);
        msr = 0;

        // R2 corners
        run(0, 8'h7F, 8'h01, 0, 1'b1);
        run(0, 8'hFF, 8'h01, 0, 1'b1);
        run(1, 8'h00, 8'h00, 0, 1'b1);
        run(1, 8'h0F, 8'h80, 0, 1'b1);
        // R3 corners
        run(2, 8'h80, 8'h01, 0, 1'b1);
        run(2, 8'h00, 8'h01, 0, 1'b1);
        run(2, 8'h10, 8'h01, 0, 1'b1);
        // R4: multi-byte compare keeps Z only while already set
        run(2, 8'h05, 8'h05, 0, 1'b1);
        run(3, 8'h12, 8'h12, 0, 1'b1);
        run(2, 8'h06, 8'h05, 0, 1'b1);
        run(3, 8'h33, 8'h33, 0, 1'b1);
        run(2, 8'h00, 8'h01, 0, 1'b1);
        run(3, 8'h01, 8'h00, 0, 1'b1);
        // R5 with C and H set beforehand
        run(18, 0, 0, 0, 1'b1);
        run(18, 0, 0, 5, 1'b1);
        run(4, 8'hF0, 8'h0F, 0, 1'b1);
        run(7, 8'hFF, 8'h0F, 0, 1'b1);
        // R6
        run(8, 8'h00, 0, 0, 1'b1);
        run(9, 8'h80, 0, 0, 1'b1);
        run(9, 8'h00, 0, 0, 1'b1);
        run(9, 8'h10, 0, 0, 1'b1);
        // R7
        run(10, 8'h7F, 0, 0, 1'b1);
        run(11, 8'h80, 0, 0, 1'b1);
        run(10, 8'hFF, 0, 0, 1'b1);
        // R8 / R9
        run(12, 8'h81, 0, 0, 1'b1);
        run(13, 8'h01, 0, 0, 1'b1);
        run(18, 0, 0, 0, 1'b1);
        run(14, 8'h40, 0, 0, 1'b1);
        run(18, 0, 0, 0, 1'b1);
        run(15, 8'h02, 0, 0, 1'b1);
        run(16, 8'h81, 0, 0, 1'b1);
        // R10
        run(17, 8'h3C, 0, 0, 1'b1);
        // R11 every bit
        for (int k = 0; k < 8; k++) run(18, 8'hA5, 0, k, 1'b1);
        for (int k = 0; k < 8; k++) run(19, 8'h5A, 0, k, 1'b1);
        // R1 hold with a flag-changing op
        run(8, 8'h00, 0, 0, 1'b0);

        for (int i = 0; i < N_RANDOM; i++) begin
            int op, a, b;
            op = int'($urandom_range(0, 19));
            case ($urandom_range(0, 7))
                0:       a = 8'h7F;
                1:       a = 8'h80;
                2:       a = 8'h00;
                3:       a = 8'hFF;
                default: a = int'($urandom_range(0, 255));
            endcase
            b = int'($urandom_range(0, 255));
            run(op, a, b, int'($urandom_range(0, 7)), ($urandom_range(0, 9) != 0));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule